// File: doc/BRIEF.md
# Audio Port Control and Status Register Bank

This block is the software-visible register bank of a serial audio port. It keeps one control word and one status word. Every word has three write views: a plain view that replaces the value, a set view that ORs the written ones into it, and a clear view that removes the written ones from it. Software can therefore start the engine, stop it, or acknowledge one error flag without first reading the register back.

The control word holds a soft-reset bit and a clock-gate bit, and both must be cleared before anything else in the port will respond. It also holds the run bit that drives the serial engine, an enable that lets FIFO errors reach the interrupt line, a receive-direction bit, a follower (external clocking) bit and a small format field. These fields go out as plain outputs. The status word reports whether the engine is running and keeps two sticky flags. One flag records that the transmit FIFO ran dry and the other that the receive FIFO overflowed. Each flag is set by a single-cycle event pulse from the datapath.

The bus is a single-cycle synchronous write strobe with a word address. Read data is combinational from the address.

Top module: `aud_csr_bank`

## Requirements
- R1: After reset the control word reads 0xC000_0000 (soft reset bit 31 and clock gate bit 30 set), the status word reads 0, and `err_irq` and `eng_run` are low.
- R2: A write to word address 0 (control, plain view) replaces the control word. The implemented bits are 31, 30 and 8..0, with run at bit 0, error-interrupt enable at bit 1, receive at bit 2, follower at bit 3 and format at bits 8..4; all other bits read 0. `eng_rx_mode`, `eng_follower` and `eng_fmt` show the matching bits.
- R3: A write to word address 1 (control, set view) sets every written 1 and leaves the other bits unchanged.
- R4: A write to word address 2 (control, clear view) clears every written 1 and leaves the other bits unchanged.
- R5: While bit 31 or bit 30 of the control word is 1, writes can change only bits 31 and 30. Status writes and FIFO events are ignored during this time.
- R6: Any write that leaves bit 31 at 1 restores the control word to 0xC000_0000 and clears both status flags in the same cycle.
- R7: `eng_run` and status bit 0 (busy) are high exactly when run is 1 and bits 31 and 30 are both 0.
- R8: A `fifo_underflow` pulse sets status bit 1 and a `fifo_overflow` pulse sets status bit 2. A flag stays set until software clears it.
- R9: Writing a 1 to a flag through word address 6 (status, clear view) clears that flag. An event arriving in the same cycle as the clear keeps the flag set.
- R10: `err_irq` is high exactly when the error-interrupt enable is 1 and at least one status flag is set.
- R11: Writes to word address 4 (status, plain view) and 5 (status, set view) affect only the flag bits 2..1. The busy bit does not follow written data.
- R12: Writes to word addresses 3 and 7 have no effect, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word address: bit 2 selects status, bits 1..0 select plain/set/clear view |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fifo_underflow | input | 1 | Single-cycle transmit FIFO underflow event |
| fifo_overflow | input | 1 | Single-cycle receive FIFO overflow event |
| eng_run | output | 1 | Serial engine run enable |
| eng_rx_mode | output | 1 | Receive direction selected |
| eng_follower | output | 1 | Engine takes its bit and frame clocks from outside |
| eng_fmt | output | FMT_W | Frame format field |
| err_irq | output | 1 | FIFO error interrupt |

## Verification
Every register state is visible at the ports in the cycle after the write or event that changed it. A wrong control bit shows on `reg_rdata` at address 0 and on the engine outputs one clock after the write. A lost or phantom flag shows on `reg_rdata` at address 4 and on `err_irq` one clock after the event or clear. A broken freeze or soft-reset path is therefore caught by the next comparison against a model that tracks the gated state, with no hidden state building up between checks.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
  localparam int WORD_W  = 32;
  localparam int SR_BIT  = 31;
  localparam int CG_BIT  = 30;
  localparam int RUN_BIT = 0;
  localparam int IE_BIT  = 1;
  localparam int RX_BIT  = 2;
  localparam int FOL_BIT = 3;
  localparam int FMT_LSB = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } csr_op_e;

  // bits that survive and define the soft-reset state
  localparam word_t HOLD_BITS = (word_t'(1) << SR_BIT) | (word_t'(1) << CG_BIT);

  // apply one of the three write views to a word
  function automatic word_t csr_apply(word_t old, word_t data, csr_op_e op);
    case (op)
      OP_WRITE: return data;
      OP_SET:   return old | data;
      OP_CLEAR: return old & ~data;
      default:  return old;
    endcase
  endfunction

  // single-bit form of the same rule
  function automatic logic bit_apply(logic old, logic d, csr_op_e op);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return old | d;
      OP_CLEAR: return old & ~d;
      default:  return old;
    endcase
  endfunction

  // implemented control bits for a given format width
  function automatic word_t ctrl_mask(int fmt_w);
    word_t m;
    m = HOLD_BITS;
    for (int i = 0; i < FMT_LSB + fmt_w; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/aud_csr_decode.sv
module aud_csr_decode
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output csr_op_e           op,
  output logic              ctrl_wr,
  output logic              stat_wr,
  output logic              ctrl_rd,
  output logic              stat_rd
);
  localparam int SEL_BIT = 2;

  logic hi_ok;
  logic view_ok;

  generate
    if (ADDR_W > 3) begin : g_hi
      assign hi_ok = ~|addr[ADDR_W-1:3];
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  assign op      = csr_op_e'(addr[1:0]);
  assign view_ok = hi_ok && (op != OP_NONE);
  assign ctrl_rd = view_ok && !addr[SEL_BIT];
  assign stat_rd = view_ok &&  addr[SEL_BIT];
  assign ctrl_wr = wr && ctrl_rd;
  assign stat_wr = wr && stat_rd;
endmodule

// File: rtl/aud_csr_ctrl.sv
module aud_csr_ctrl
  import aud_csr_pkg::*;
#(
  parameter int FMT_W = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_hit,
  input  csr_op_e op,
  input  word_t   wdata,
  output word_t   ctrl_q,
  output logic    gated,
  output logic    sr_apply
);
  localparam word_t MASK = ctrl_mask(FMT_W);

  word_t raw;
  word_t merged;
  word_t nxt;

  assign gated = ctrl_q[SR_BIT] | ctrl_q[CG_BIT];

  always_comb begin
    raw = wr_hit ? csr_apply(ctrl_q, wdata & MASK, op) : ctrl_q;
    // while gated only the reset and gate bits may move
    merged = gated ? ((raw & HOLD_BITS) | (ctrl_q & ~HOLD_BITS)) : raw;
    sr_apply = merged[SR_BIT];
    nxt = sr_apply ? HOLD_BITS : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= HOLD_BITS;
    else        ctrl_q <= nxt;
  end
endmodule

// File: rtl/aud_csr_stat.sv
module aud_csr_stat
  import aud_csr_pkg::*;
#(
  parameter int N_FLAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  csr_op_e           op,
  input  logic [N_FLAG-1:0] wflags,
  input  logic [N_FLAG-1:0] ev,
  input  logic              gated,
  input  logic              sr_apply,
  output logic [N_FLAG-1:0] flags_q,
  output logic [N_FLAG-1:0] ev_take,
  output logic [N_FLAG-1:0] clr_req
);
  generate
    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
      logic q;
      logic sw;
      logic nxt;

      always_comb begin
        sw = wr_hit ? bit_apply(q, wflags[i], op) : q;
        if (sr_apply)   nxt = 1'b0;
        else if (gated) nxt = q;
        else            nxt = sw | ev[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
      end

      assign flags_q[i] = q;
      assign ev_take[i] = ev[i] & ~gated;
      assign clr_req[i] = wr_hit && ((op == OP_CLEAR && wflags[i]) ||
                                     (op == OP_WRITE && !wflags[i]));
    end
  endgenerate
endmodule

// File: rtl/aud_csr_bank.sv
module aud_csr_bank
  import aud_csr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int FMT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fifo_underflow,
  input  logic              fifo_overflow,
  output logic              eng_run,
  output logic              eng_rx_mode,
  output logic              eng_follower,
  output logic [FMT_W-1:0]  eng_fmt,
  output logic              err_irq
);
  localparam int N_FLAG = 2;
  localparam int FMT_HI = FMT_LSB + FMT_W - 1;

  csr_op_e           op;
  logic              ctrl_wr, stat_wr, ctrl_rd, stat_rd;
  word_t             ctrl_q;
  logic              gated, sr_apply;
  logic [N_FLAG-1:0] flags_q, ev_take, clr_req;
  logic              busy;
  word_t             stat_word;

  aud_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr(reg_wr), .addr(reg_addr), .op(op),
    .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd)
  );

  aud_csr_ctrl #(.FMT_W(FMT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_wr), .op(op),
    .wdata(reg_wdata), .ctrl_q(ctrl_q), .gated(gated), .sr_apply(sr_apply)
  );

  aud_csr_stat #(.N_FLAG(N_FLAG)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_hit(stat_wr), .op(op),
    .wflags(reg_wdata[N_FLAG:1]), .ev({fifo_overflow, fifo_underflow}),
    .gated(gated), .sr_apply(sr_apply),
    .flags_q(flags_q), .ev_take(ev_take), .clr_req(clr_req)
  );

  assign busy = ctrl_q[RUN_BIT] & ~gated;

  always_comb begin
    stat_word = '0;
    stat_word[0] = busy;
    stat_word[N_FLAG:1] = flags_q;
  end

  assign reg_rdata    = ctrl_rd ? ctrl_q : (stat_rd ? stat_word : '0);
  assign eng_run      = busy;
  assign eng_rx_mode  = ctrl_q[RX_BIT];
  assign eng_follower = ctrl_q[FOL_BIT];
  assign eng_fmt      = ctrl_q[FMT_HI:FMT_LSB];
  assign err_irq      = ctrl_q[IE_BIT] & (|flags_q);
endmodule

// File: rtl/aud_csr_bank_chk.sv
module aud_csr_bank_chk
  import aud_csr_pkg::*;
#(
  parameter int N_FLAG = 2,
  parameter int FMT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input word_t             ctrl_q,
  input logic              gated,
  input logic              sr_apply,
  input logic [N_FLAG-1:0] flags_q,
  input logic [N_FLAG-1:0] ev_take,
  input logic [N_FLAG-1:0] clr_req,
  input logic              err_irq,
  input logic              eng_run
);
  localparam int FIELD_HI = FMT_LSB + FMT_W - 1;

  AST_SR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_apply |=> (ctrl_q == HOLD_BITS) && (flags_q == '0)); // R6

  AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !sr_apply) |=> $stable(ctrl_q[FIELD_HI:0])); // R5

  AST_GATED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !sr_apply) |=> $stable(flags_q)); // R5

  AST_RUN_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run |-> (!gated && ctrl_q[RUN_BIT])); // R7

  AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ctrl_q[IE_BIT]); // R10

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (|flags_q)); // R10

  generate
    for (genvar i = 0; i < N_FLAG; i++) begin : g_fl
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[i] && !clr_req[i] && !sr_apply) |=> flags_q[i]); // R8

      AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take[i] && !sr_apply) |=> flags_q[i]); // R9
    end
  endgenerate
endmodule

bind aud_csr_bank aud_csr_bank_chk #(.N_FLAG(N_FLAG), .FMT_W(FMT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .gated(gated),
  .sr_apply(sr_apply), .flags_q(flags_q), .ev_take(ev_take),
  .clr_req(clr_req), .err_irq(err_irq), .eng_run(eng_run)
);

// File: tb/aud_csr_bank_test.sv
module aud_csr_bank_test;
  localparam int FMT_W = 5;
  localparam logic [31:0] HOLD = 32'hC000_0000;
  localparam logic [31:0] MASK = HOLD | ((32'd1 << (4 + FMT_W)) - 32'd1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic fifo_underflow = 1'b0;
  logic fifo_overflow = 1'b0;
  logic eng_run, eng_rx_mode, eng_follower, err_irq;
  logic [FMT_W-1:0] eng_fmt;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl;
  logic [1:0]  m_fl;

  always #10 clk = ~clk;

  aud_csr_bank #(.ADDR_W(3), .FMT_W(FMT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fifo_underflow(fifo_underflow), .fifo_overflow(fifo_overflow),
    .eng_run(eng_run), .eng_rx_mode(eng_rx_mode), .eng_follower(eng_follower),
    .eng_fmt(eng_fmt), .err_irq(err_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // reference model of one clock edge, written from the requirements
  task automatic model_edge(input logic wr, input logic [2:0] a, input logic [31:0] d,
                            input logic uf, input logic ovf);
    logic was_gated;
    logic [31:0] c;
    logic [1:0] f, wd;
    was_gated = m_ctrl[31] | m_ctrl[30];
    c = m_ctrl;
    f = m_fl;
    if (wr && !a[2] && a[1:0] != 2'd3) begin
      if (a[1:0] == 2'd0)      c = d & MASK;
      else if (a[1:0] == 2'd1) c = m_ctrl | (d & MASK);
      else                     c = m_ctrl & ~(d & MASK);
      if (was_gated) c = {c[31:30], m_ctrl[29:0]};
    end
    if (c[31]) begin
      c = HOLD;
      f = 2'b00;
    end else if (!was_gated) begin
      wd = d[2:1];
      if (wr && a[2] && a[1:0] != 2'd3) begin
        if (a[1:0] == 2'd0)      f = wd;
        else if (a[1:0] == 2'd1) f = f | wd;
        else                     f = f & ~wd;
      end
      f = f | {ovf, uf};
    end
    m_ctrl = c;
    m_fl = f;
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      input logic uf, input logic ovf);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    fifo_underflow = uf; fifo_overflow = ovf;
    @(posedge clk);
    model_edge(wr, a, d, uf, ovf);
    @(negedge clk);
    reg_wr = 1'b0; fifo_underflow = 1'b0; fifo_overflow = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic busy;
    busy = m_ctrl[0] & ~m_ctrl[31] & ~m_ctrl[30];
    reg_addr = 3'd0; #1;
    chk(req, "ctrl word", reg_rdata, m_ctrl);
    reg_addr = 3'd4; #1;
    chk(req, "status word", reg_rdata, {29'd0, m_fl, busy});
    chk("R7", "eng_run", {31'd0, eng_run}, {31'd0, busy});
    chk("R10", "err_irq", {31'd0, err_irq}, {31'd0, m_ctrl[1] & (|m_fl)});
    chk("R2", "engine fields", {25'd0, eng_fmt, eng_follower, eng_rx_mode},
        {25'd0, m_ctrl[8:4], m_ctrl[3], m_ctrl[2]});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    m_ctrl = HOLD;
    m_fl = 2'b00;
    lf = 32'h1D2C_3B4A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // leave soft reset, still clock-gated: field writes and events are frozen
    step(1, 3'd2, 32'h8000_0000, 0, 0);
    step(1, 3'd0, 32'h4000_00FF, 1, 1);
    check_all("R5");
    reg_addr = 3'd4; #1;
    chk("R5", "flags ignore events when gated", reg_rdata, 32'd0);

    // ungate through the clear view
    step(1, 3'd2, 32'h4000_0000, 0, 0);
    check_all("R4");
    step(1, 3'd0, 32'h3FFF_FFFF, 0, 0);
    check_all("R2");
    reg_addr = 3'd0; #1;
    chk("R2", "unimplemented bits read zero", reg_rdata, 32'h0000_01FF);
    chk("R7", "busy while running", {31'd0, eng_run}, 32'd1);

    // sticky flags and interrupt
    step(0, 3'd0, 32'd0, 1, 0);
    step(0, 3'd0, 32'd0, 0, 0);
    check_all("R8");
    reg_addr = 3'd4; #1;
    chk("R8", "underflow flag held", reg_rdata, 32'h0000_0003);
    step(0, 3'd0, 32'd0, 0, 1);
    check_all("R10");
    // clear underflow, overflow event collides with clear of overflow
    step(1, 3'd6, 32'h0000_0006, 0, 1);
    reg_addr = 3'd4; #1;
    chk("R9", "event beats clear", reg_rdata, 32'h0000_0005);
    step(1, 3'd6, 32'h0000_0004, 0, 0);
    reg_addr = 3'd4; #1;
    chk("R9", "clear view clears flag", reg_rdata, 32'h0000_0001);
    // status writes cannot reach busy
    step(1, 3'd4, 32'hFFFF_FFF8, 0, 0);
    reg_addr = 3'd4; #1;
    chk("R11", "plain status write", reg_rdata, 32'h0000_0001);
    step(1, 3'd5, 32'h0000_0002, 0, 0);
    check_all("R11");
    // stop the engine via clear view
    step(1, 3'd2, 32'h0000_0001, 0, 0);
    check_all("R7");
    // undefined views
    step(1, 3'd3, 32'h0000_0000, 0, 0);
    step(1, 3'd7, 32'h0000_0006, 0, 0);
    check_all("R12");
    reg_addr = 3'd3; #1;
    chk("R12", "read view 3", reg_rdata, 32'd0);
    reg_addr = 3'd7; #1;
    chk("R12", "read view 7", reg_rdata, 32'd0);
    // soft reset through the set view
    step(1, 3'd1, 32'h8000_0000, 0, 0);
    check_all("R6");
    // set view after ungating
    step(1, 3'd0, 32'h0000_0000, 0, 0);
    step(1, 3'd1, 32'h0000_0014, 0, 0);
    check_all("R3");

    // sweep: every register, view and event pair over pseudo-random data
    for (int p = 0; p < 8; p++) begin
      for (int a = 0; a < 8; a++) begin
        for (int e = 0; e < 4; e++) begin
          logic [31:0] d;
          logic g;
          string tag;
          lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
          d = lf;
          if ((p + a + e) % 7 != 0) d[31] = 1'b0;
          g = m_ctrl[31] | m_ctrl[30];
          if (a[1:0] == 2'd3)  tag = "R12";
          else if (a[2])       tag = (a[1:0] == 2'd2) ? "R9" : "R11";
          else if (g)          tag = "R5";
          else if (a == 0)     tag = "R2";
          else if (a == 1)     tag = "R3";
          else                 tag = "R4";
          step(1, 3'(a), d, e[0], e[1]);
          check_all(tag);
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule